// File: doc/BRIEF.md
# IDE Register Window Adapter

This block is the bridge between a 32-bit big-endian host bus and a plain ATA task-file register interface. A host access carries an address inside a 4 KB window, a size (byte, halfword or word), a write flag and write data. The block takes the register index from address bits [11:4], so every register occupies a 16-byte slot. It forwards byte accesses to the task-file and the control/status registers. It forwards halfword and word accesses at index 0 to the data port, swapping the byte lanes in both directions. Reads from any slot that is not mapped return all ones at the access width.

The block has two registers of its own, and both respond only to word accesses. Index 0x20 is a timing register that only stores a value and reads it back. Index 0x30 is an interrupt status register. In that register, one bit latches the DMA interrupt until software clears it by writing a 1, and another bit gives a live view of the disk interrupt. Both interrupt inputs also pass straight through to their own output lines. Read data is combinational from the request. Register writes take effect at the next rising clock edge.

Top module: `ide_regwin`

## Requirements
- R1: The register index is `bus_addr[11:4]`. Address bits [3:0] have no effect on decode.
- R2: A byte access (`bus_size`=0) to index 1..7 drives `dev_idx` equal to the index and `dev_size`=0. A write also drives `dev_wr` with `dev_wdata={24'h0,bus_wdata[7:0]}`. A read also drives `dev_rd` and returns `{24'h0,dev_rdata[7:0]}`. `dev_rd` and `dev_wr` are never high together.
- R3: A byte access to index 8 or index 22 reaches the control/status register, which is `dev_idx`=8. The read and write data lanes are the same as in R2.
- R4: A byte access to any other index raises no device strobe. A byte read of such an index returns 32'h0000_00FF.
- R5: A halfword access (`bus_size`=1) at index 0 goes to the data port (`dev_idx`=0, `dev_size`=1) with the two low bytes swapped in both directions. A halfword read of any other index returns 32'h0000_FFFF and raises no strobe.
- R6: A word access (`bus_size`=2 or 3) at index 0 goes to the data port (`dev_size`=2) with all four bytes reversed in both directions. A word read of an unmapped index returns 32'hFFFF_FFFF. A word write to an unmapped index changes nothing.
- R7: A word write to index 0x20 stores the timing value at the next clock edge. A word read of index 0x20 returns exactly the value that was written. Accesses narrower than a word do not touch this register.
- R8: A word read of index 0x30 returns the DMA latch in `bus_rdata[7]` and the live disk interrupt level in `bus_rdata[6]`. All other bits read as zero. This is the byte-reversed image of register bits 31 and 30.
- R9: The DMA latch is set at every clock edge where `dma_irq_in` is high. A word write to index 0x30 with `bus_wdata[7]`=1 clears the latch. If a set and a clear fall in the same cycle, the set wins. All other written bits have no effect.
- R10: `disk_irq_out` follows `disk_irq_in` and `dma_irq_out` follows `dma_irq_in`, with no delay.
- R11: Reset clears the timing register and the DMA latch to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| bus_addr | input | 12 | Byte address inside the window |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data |
| dev_idx | output | 4 | Device register: 0 data, 1..7 task file, 8 control/status |
| dev_size | output | 2 | Device access width |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| dev_wdata | output | 32 | Lane-adjusted data to device |
| dev_rdata | input | 32 | Raw data from device |
| disk_irq_in | input | 1 | Disk interrupt level |
| dma_irq_in | input | 1 | DMA interrupt |
| disk_irq_out | output | 1 | Forwarded disk interrupt |
| dma_irq_out | output | 1 | Forwarded DMA interrupt |

## Verification
Random accesses draw their index from a pool made of every mapped slot and of arbitrary indices. Each access also gets a random low address nibble, a random size and a random direction, so that every size is tried against every kind of slot. This tells apart correct routing, the byte swap at each width, and the fill value of each width on unmapped slots. The interrupt inputs toggle at random while the DMA latch is read and cleared, which separates a sticky latch from a live copy. Directed cases cover the clear that arrives together with a set, a clear written in the wrong lane, and narrow accesses to the word-only registers.

// File: rtl/ide_regwin.sv
module ide_regwin #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [1:0]    bus_size,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [3:0]    dev_idx,
  output logic [1:0]    dev_size,
  output logic          dev_rd,
  output logic          dev_wr,
  output logic [DW-1:0] dev_wdata,
  input  logic [DW-1:0] dev_rdata,
  input  logic          disk_irq_in,
  input  logic          dma_irq_in,
  output logic          disk_irq_out,
  output logic          dma_irq_out
);
  localparam int IW = AW - 4;

  logic [IW-1:0] idx;
  logic is_b, is_h, is_w;
  logic tf_hit, cs_hit, data_hit, tim_hit, irq_hit, dev_hit;
  logic [31:0] timing_q;
  logic        dma_q;
  logic        dma_clr;

  function automatic logic [31:0] swap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  assign idx  = bus_addr[AW-1:4];
  assign is_b = (bus_size == 2'd0);
  assign is_h = (bus_size == 2'd1);
  assign is_w = bus_size[1];

  assign tf_hit   = is_b && (idx >= IW'(1)) && (idx <= IW'(7));
  assign cs_hit   = is_b && (idx == IW'(8) || idx == IW'(22));
  assign data_hit = (is_h || is_w) && (idx == '0);
  assign tim_hit  = is_w && (idx == IW'(8'h20));
  assign irq_hit  = is_w && (idx == IW'(8'h30));
  assign dev_hit  = bus_sel && (tf_hit || cs_hit || data_hit);

  assign dev_rd   = dev_hit && !bus_we;
  assign dev_wr   = dev_hit && bus_we;
  assign dev_idx  = cs_hit ? 4'd8 : (tf_hit ? idx[3:0] : 4'd0);
  assign dev_size = is_w ? 2'd2 : bus_size;

  always_comb begin
    if (is_w)      dev_wdata = swap32(bus_wdata);
    else if (is_h) dev_wdata = {16'h0, bus_wdata[7:0], bus_wdata[15:8]};
    else           dev_wdata = {24'h0, bus_wdata[7:0]};
  end

  always_comb begin
    if (tf_hit || cs_hit)     bus_rdata = {24'h0, dev_rdata[7:0]};
    else if (data_hit && is_h) bus_rdata = {16'h0, dev_rdata[7:0], dev_rdata[15:8]};
    else if (data_hit)        bus_rdata = swap32(dev_rdata);
    else if (tim_hit)         bus_rdata = swap32(timing_q);
    else if (irq_hit)         bus_rdata = swap32({dma_q, disk_irq_in, 30'h0});
    else if (is_b)            bus_rdata = 32'h0000_00FF;
    else if (is_h)            bus_rdata = 32'h0000_FFFF;
    else                      bus_rdata = 32'hFFFF_FFFF;
  end

  assign dma_clr = bus_sel && bus_we && irq_hit && swap32(bus_wdata)[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timing_q <= '0;
      dma_q    <= 1'b0;
    end else begin
      if (bus_sel && bus_we && tim_hit) timing_q <= swap32(bus_wdata);
      dma_q <= dma_irq_in | (dma_q & ~dma_clr);
    end
  end

  assign disk_irq_out = disk_irq_in;
  assign dma_irq_out  = dma_irq_in;

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_rd && dev_wr));
  // R4
  unmapped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && is_b && !(idx inside {IW'(1), IW'(2), IW'(3), IW'(4), IW'(5),
      IW'(6), IW'(7), IW'(8), IW'(22)})) |-> !dev_rd && !dev_wr);
  // R7
  timing_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_we && bus_size[1] && bus_addr[AW-1:4] == IW'(8'h20))
      |=> $stable(timing_q));
  // R9
  dma_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_irq_in |=> dma_q);
  // R9
  dma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_q && !(bus_sel && bus_we && bus_wdata[7])) |=> dma_q);
endmodule

// File: tb/ide_regwin_test.sv
module ide_regwin_test;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [1:0] bus_size = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, dev_wdata, dev_rdata = 0;
  logic [3:0] dev_idx;
  logic [1:0] dev_size;
  logic dev_rd, dev_wr, disk_irq_in = 0, dma_irq_in = 0, disk_irq_out, dma_irq_out;
  int checks = 0, errors = 0;
  logic [31:0] m_tim = 0;
  logic m_dma = 0;

  always #4 clk = ~clk;

  ide_regwin uut (.*);

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [31:0] sw(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [1:0] sz, input logic [7:0] ix,
                        input logic [3:0] lo, input logic [31:0] wd);
    logic [31:0] er;
    logic ehit;
    logic [3:0] eidx;
    logic [31:0] ewd;
    logic clr;
    @(negedge clk);
    bus_sel = 1; bus_we = we; bus_size = sz; bus_addr = {ix, lo}; bus_wdata = wd;
    dev_rdata = $urandom;
    #2;
    ehit = 0; eidx = 0; er = 0; ewd = 0;
    if (sz == 0) begin
      ewd = {24'h0, wd[7:0]};
      if (ix >= 1 && ix <= 7) begin ehit = 1; eidx = ix[3:0]; er = {24'h0, dev_rdata[7:0]}; end
      else if (ix == 8 || ix == 22) begin ehit = 1; eidx = 8; er = {24'h0, dev_rdata[7:0]}; end
      else er = 32'hFF;
    end else if (sz == 1) begin
      ewd = {16'h0, wd[7:0], wd[15:8]};
      if (ix == 0) begin ehit = 1; er = {16'h0, dev_rdata[7:0], dev_rdata[15:8]}; end
      else er = 32'hFFFF;
    end else begin
      ewd = sw(wd);
      if (ix == 0) begin ehit = 1; er = sw(dev_rdata); end
      else if (ix == 8'h20) er = m_tim;
      else if (ix == 8'h30) er = {24'h0, m_dma, disk_irq_in, 6'h0};
      else er = 32'hFFFFFFFF;
    end
    // R2 R3 R4 R5 R6 strobes and index
    chk("R2 dev_rd", {31'h0, dev_rd}, {31'h0, ehit && !we});
    chk("R4 dev_wr", {31'h0, dev_wr}, {31'h0, ehit && we});
    if (ehit) begin
      chk("R3 dev_idx", {28'h0, dev_idx}, {28'h0, eidx});
      chk("R1 dev_size", {30'h0, dev_size}, {30'h0, sz[1] ? 2'd2 : sz});
      if (we) chk("R5 dev_wdata", dev_wdata, ewd);
    end
    if (!we) chk("R6 R7 R8 rdata", bus_rdata, er);
    // R10
    chk("R10 irq out", {30'h0, disk_irq_out, dma_irq_out}, {30'h0, disk_irq_in, dma_irq_in});
    clr = we && sz[1] && ix == 8'h30 && wd[7];
    if (we && sz[1] && ix == 8'h20) m_tim = wd;
    m_dma = dma_irq_in | (m_dma & ~clr);
    @(posedge clk);
    #1;
    bus_sel = 0;
  endtask

  initial begin
    logic [7:0] pool [12] = '{8'd0, 8'd1, 8'd4, 8'd7, 8'd8, 8'd22, 8'h20, 8'h30, 8'd9, 8'd23, 8'h21, 8'hFF};
    void'($urandom(32'd1234));
    #20;
    // R11 reset state
    access(0, 2, 8'h20, 0, 0);
    access(0, 2, 8'h30, 4'h5, 0);
    rst_n = 1;
    access(0, 2, 8'h20, 0, 0);
    // R7 word store and narrow ignore
    access(1, 2, 8'h20, 4'hC, 32'h1234_5678);
    access(1, 0, 8'h20, 0, 32'hFFFF_FFFF);
    access(1, 1, 8'h20, 0, 32'hFFFF_FFFF);
    access(0, 2, 8'h20, 0, 0);
    access(0, 0, 8'h20, 0, 0);
    // R9 set, hold, wrong-lane clear, clear, set wins
    dma_irq_in = 1; access(0, 2, 8'h30, 0, 0);
    dma_irq_in = 0; access(0, 2, 8'h30, 0, 0);
    access(1, 2, 8'h30, 0, 32'h8000_007F);
    access(0, 2, 8'h30, 0, 0);
    dma_irq_in = 1; access(1, 2, 8'h30, 0, 32'h80);
    dma_irq_in = 0; access(0, 2, 8'h30, 0, 0);
    access(1, 2, 8'h30, 0, 32'h80);
    access(0, 2, 8'h30, 0, 0);
    // R8 live disk bit
    disk_irq_in = 1; access(0, 2, 8'h30, 0, 0);
    disk_irq_in = 0; access(0, 2, 8'h30, 0, 0);
    for (int i = 0; i < 600; i++) begin
      logic [7:0] ix;
      ix = ($urandom % 4 == 0) ? 8'($urandom) : pool[$urandom % 12];
      disk_irq_in = $urandom % 2;
      dma_irq_in = ($urandom % 8) == 0;
      access(1'($urandom), 2'($urandom), ix, 4'($urandom), $urandom);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule